// File: doc/BRIEF.md
# Fault-Aware Set-Associative Cache Controller

This block holds the tags, the status bits and a small data array of a set-associative cache. Beside its valid bit, every line also carries a fault flag. Once that flag is raised, the line acts as if it were not there. Lookups never hit on it, and the refill logic never picks it as a victim. The set carries on caching with its remaining healthy ways.

Three request ports share one clock. The lookup port takes a word address and answers one cycle later with hit, way and data. The refill port installs a line for an address. The installed data comes from a backing memory outside the block. The marking port flags one line, named by set and way, as faulty. In a system this flag comes from production test or from an error detector.

Top module: `fault_aware_cache`

## Requirements
- R1: A fault flag, once raised through the marking port, stays raised until reset. A faulty line is never filled again: later refills to that set never report its way.
- R2: A lookup whose tag matches a line that has been marked faulty reports a miss, even if the line held that tag before marking.
- R3: The refill logic never selects a faulty way as the victim.
- R4: In a 4-way set with one faulty way, three distinct addresses of that set stay resident together and all hit.
- R5: If every way of a set is faulty, a refill to it reports fill_ok=0 and allocates nothing, and every lookup to that set misses.
- R6: Marking a line invalidates it in the same edge. A lookup issued in the same cycle as the mark still sees the old contents. A lookup issued one cycle later misses.
- R7: lk_done, lk_hit, lk_way and lk_data are valid exactly one cycle after lk_req and reflect the state before that edge. A refill issued in the same cycle is not yet visible.
- R8: Refill placement works in this order:
  - If the tag is already resident in a healthy way, that way is overwritten in place.
  - Otherwise the lowest-index invalid healthy way is used.
  - Otherwise the choice is round-robin over the healthy ways, starting from the set's pointer.
  - After a victim is chosen, the pointer moves to the next way (way+1, wrapping). An in-place overwrite leaves the pointer unchanged.
  - fill_done, fill_ok and fill_way appear one cycle after fill_req.
- R9: After reset every line is invalid and healthy, all outputs are 0, and any lookup misses.
- R10: The set index is the low log2(SETS) bits of the address and the tag is the remaining upper bits. Addresses that differ only in the tag compete for the same set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Lookup word address |
| lk_done | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | WAY_W | Way that hit (0 on miss) |
| lk_data | output | DATA_W | Data of the hitting line (0 on miss) |
| fill_req | input | 1 | Refill request |
| fill_addr | input | ADDR_W | Refill word address |
| fill_data | input | DATA_W | Refill data from backing memory |
| fill_done | output | 1 | Refill result valid (one cycle after request) |
| fill_ok | output | 1 | Line was installed |
| fill_way | output | WAY_W | Way that received the line |
| mark_req | input | 1 | Mark a line faulty |
| mark_set | input | IDX_W | Set of the line to mark |
| mark_way | input | WAY_W | Way of the line to mark |

## Verification
The hardest state to reach from the ports is a full set of valid lines with a hole in it. In that state the round-robin pointer must step over a faulty way. The stimulus gets there in steps:
- It marks one way of a fresh set faulty.
- It fills the three healthy ways through the lowest-invalid rule.
- It forces two further refills. Their predicted ways show that the pointer skips the faulty way.

The same-cycle cases are driven as single-cycle overlaps at the ports:
- A mark together with a lookup of the same line.
- A refill together with a lookup of the same address.

// File: rtl/fac_pkg.sv
package fac_pkg;

  // Index of the lowest set bit among the first n bits; -1 when none is set.
  function automatic int lowest_one(input logic [31:0] vec, input int n);
    int res;
    res = -1;
    for (int i = n - 1; i >= 0; i--) begin
      if (vec[i]) res = i;
    end
    return res;
  endfunction

endpackage

// File: rtl/fac_tag_store.sv
module fac_tag_store #(
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3,
  parameter int WAY_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  // read port A (lookup side)
  input  logic [IDX_W-1:0]             ra_idx,
  output logic [WAYS-1:0]              ra_valid,
  output logic [WAYS-1:0]              ra_fault,
  output logic [WAYS-1:0][TAG_W-1:0]   ra_tags,
  output logic [WAYS-1:0][DATA_W-1:0]  ra_data,
  // read port B (refill side)
  input  logic [IDX_W-1:0]             rb_idx,
  output logic [WAYS-1:0]              rb_valid,
  output logic [WAYS-1:0]              rb_fault,
  output logic [WAYS-1:0][TAG_W-1:0]   rb_tags,
  // line install
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [WAY_W-1:0]             wr_way,
  input  logic [TAG_W-1:0]             wr_tag,
  input  logic [DATA_W-1:0]            wr_data,
  // fault marking
  input  logic                         mk_en,
  input  logic [IDX_W-1:0]             mk_idx,
  input  logic [WAY_W-1:0]             mk_way
);

  logic [SETS-1:0][WAYS-1:0] valid_q, valid_d;
  logic [SETS-1:0][WAYS-1:0] fault_q, fault_d;
  logic [TAG_W-1:0]          tag_q  [SETS][WAYS];
  logic [DATA_W-1:0]         data_q [SETS][WAYS];

  // read ports
  always_comb begin
    ra_valid = valid_q[ra_idx];
    ra_fault = fault_q[ra_idx];
    rb_valid = valid_q[rb_idx];
    rb_fault = fault_q[rb_idx];
    for (int w = 0; w < WAYS; w++) begin
      ra_tags[w] = tag_q[ra_idx][w];
      ra_data[w] = data_q[ra_idx][w];
      rb_tags[w] = tag_q[rb_idx][w];
    end
  end

  // status next state: install first, marking last so it wins on the same line
  always_comb begin
    valid_d = valid_q;
    fault_d = fault_q;
    if (wr_en) valid_d[wr_idx][wr_way] = 1'b1;
    if (mk_en) begin
      fault_d[mk_idx][mk_way] = 1'b1;
      valid_d[mk_idx][mk_way] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      fault_q <= '0;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
    end
  end

  // payload arrays: no reset, written only under the install enable
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx][wr_way]  <= wr_tag;
      data_q[wr_idx][wr_way] <= wr_data;
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(fault_q) & ~fault_q) == '0)); // R1

  AST_FAULTY_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ((fault_q & valid_q) == '0)); // R6

endmodule

// File: rtl/fac_match.sv
module fac_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 9,
  parameter int WAY_W = 2
) (
  input  logic [TAG_W-1:0]            tag,
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0]             fault,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  output logic                        hit,
  output logic [WAY_W-1:0]            way
);
  import fac_pkg::*;

  logic [WAYS-1:0] match_vec;
  int              first;

  // a faulty line is excluded from matching even if its tag agrees
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      match_vec[w] = valid[w] && !fault[w] && (tags[w] == tag);
    end
  end

  always_comb begin
    first = lowest_one(32'(match_vec), WAYS);
    hit   = (first >= 0);
    way   = hit ? WAY_W'(first) : '0;
  end

endmodule

// File: rtl/fac_victim.sv
module fac_victim #(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic [WAYS-1:0]  healthy,
  input  logic [WAYS-1:0]  valid,
  input  logic [WAY_W-1:0] ptr,
  output logic             ok,
  output logic [WAY_W-1:0] way
);
  import fac_pkg::*;

  logic [WAYS-1:0] free_vec;
  int              free_first;
  int              rr_pick;

  always_comb begin
    free_vec   = healthy & ~valid;
    free_first = lowest_one(32'(free_vec), WAYS);
  end

  // round-robin scan from the pointer over healthy ways only
  always_comb begin
    int cand;
    rr_pick = -1;
    for (int k = 0; k < WAYS; k++) begin
      cand = (int'(ptr) + k) % WAYS;
      if (rr_pick < 0 && healthy[cand]) rr_pick = cand;
    end
  end

  always_comb begin
    if (free_first >= 0) begin
      ok  = 1'b1;
      way = WAY_W'(free_first);
    end else if (rr_pick >= 0) begin
      ok  = 1'b1;
      way = WAY_W'(rr_pick);
    end else begin
      ok  = 1'b0;
      way = '0;
    end
  end

endmodule

// File: rtl/fault_aware_cache.sv
module fault_aware_cache #(
  parameter int ADDR_W = 12,
  parameter int SETS   = 8,
  parameter int WAYS   = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [WAY_W-1:0]  lk_way,
  output logic [DATA_W-1:0] lk_data,
  input  logic              fill_req,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data,
  output logic              fill_done,
  output logic              fill_ok,
  output logic [WAY_W-1:0]  fill_way,
  input  logic              mark_req,
  input  logic [IDX_W-1:0]  mark_set,
  input  logic [WAY_W-1:0]  mark_way
);

  // address split
  logic [IDX_W-1:0] lk_idx, fl_idx;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  assign lk_idx = lk_addr[IDX_W-1:0];
  assign lk_tag = lk_addr[ADDR_W-1:IDX_W];
  assign fl_idx = fill_addr[IDX_W-1:0];
  assign fl_tag = fill_addr[ADDR_W-1:IDX_W];

  // storage read data
  logic [WAYS-1:0]             a_valid, a_fault, b_valid, b_fault;
  logic [WAYS-1:0][TAG_W-1:0]  a_tags, b_tags;
  logic [WAYS-1:0][DATA_W-1:0] a_data;

  // decisions
  logic             lk_hit_c, fl_hit_c, vic_ok, fl_ok_c, wr_en;
  logic [WAY_W-1:0] lk_way_c, fl_hit_way, vic_way, fl_way_c;

  // round-robin pointers
  logic [SETS-1:0][WAY_W-1:0] rr_q, rr_d;

  fac_tag_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .ra_idx   (lk_idx),
    .ra_valid (a_valid),
    .ra_fault (a_fault),
    .ra_tags  (a_tags),
    .ra_data  (a_data),
    .rb_idx   (fl_idx),
    .rb_valid (b_valid),
    .rb_fault (b_fault),
    .rb_tags  (b_tags),
    .wr_en    (wr_en),
    .wr_idx   (fl_idx),
    .wr_way   (fl_way_c),
    .wr_tag   (fl_tag),
    .wr_data  (fill_data),
    .mk_en    (mark_req),
    .mk_idx   (mark_set),
    .mk_way   (mark_way)
  );

  fac_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk_match (
    .tag   (lk_tag),
    .valid (a_valid),
    .fault (a_fault),
    .tags  (a_tags),
    .hit   (lk_hit_c),
    .way   (lk_way_c)
  );

  fac_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_fl_match (
    .tag   (fl_tag),
    .valid (b_valid),
    .fault (b_fault),
    .tags  (b_tags),
    .hit   (fl_hit_c),
    .way   (fl_hit_way)
  );

  fac_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .healthy (~b_fault),
    .valid   (b_valid),
    .ptr     (rr_q[fl_idx]),
    .ok      (vic_ok),
    .way     (vic_way)
  );

  // refill placement: in-place overwrite beats fresh allocation
  always_comb begin
    fl_ok_c  = fl_hit_c || vic_ok;
    fl_way_c = fl_hit_c ? fl_hit_way : vic_way;
    wr_en    = fill_req && fl_ok_c;
  end

  // pointer next state
  always_comb begin
    rr_d = rr_q;
    if (fill_req && !fl_hit_c && vic_ok) begin
      rr_d[fl_idx] = (int'(vic_way) == WAYS - 1) ? '0 : vic_way + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // response registers
  logic              lk_done_d, lk_hit_d, fill_done_d, fill_ok_d;
  logic [WAY_W-1:0]  lk_way_d, fill_way_d;
  logic [DATA_W-1:0] lk_data_d;

  always_comb begin
    lk_done_d   = lk_req;
    lk_hit_d    = lk_req && lk_hit_c;
    lk_way_d    = lk_hit_d ? lk_way_c : '0;
    lk_data_d   = lk_hit_d ? a_data[lk_way_c] : '0;
    fill_done_d = fill_req;
    fill_ok_d   = wr_en;
    fill_way_d  = wr_en ? fl_way_c : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_done   <= 1'b0;
      lk_hit    <= 1'b0;
      lk_way    <= '0;
      lk_data   <= '0;
      fill_done <= 1'b0;
      fill_ok   <= 1'b0;
      fill_way  <= '0;
    end else begin
      lk_done   <= lk_done_d;
      lk_hit    <= lk_hit_d;
      lk_way    <= lk_way_d;
      lk_data   <= lk_data_d;
      fill_done <= fill_done_d;
      fill_ok   <= fill_ok_d;
      fill_way  <= fill_way_d;
    end
  end

  AST_VICTIM_HEALTHY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && vic_ok) |-> !b_fault[vic_way]); // R3

  AST_FULL_FAULT_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && (&b_fault)) |=> !fill_ok); // R5

  AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_done |-> $past(lk_req)); // R7

  AST_HIT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_done); // R7

  AST_FILL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok |-> $past(fill_req)); // R8

endmodule

// File: tb/test_fault_aware_cache.sv
module test_fault_aware_cache;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req, fill_req, mark_req;
  logic [11:0] lk_addr, fill_addr;
  logic [15:0] fill_data;
  logic [2:0]  mark_set;
  logic [1:0]  mark_way;
  logic        lk_done, lk_hit, fill_done, fill_ok;
  logic [1:0]  lk_way, fill_way;
  logic [15:0] lk_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #10 clk = ~clk; // 50 MHz

  fault_aware_cache i_fault_aware_cache (
    .clk(clk), .rst_n(rst_n),
    .lk_req(lk_req), .lk_addr(lk_addr), .lk_done(lk_done), .lk_hit(lk_hit),
    .lk_way(lk_way), .lk_data(lk_data),
    .fill_req(fill_req), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_done(fill_done), .fill_ok(fill_ok), .fill_way(fill_way),
    .mark_req(mark_req), .mark_set(mark_set), .mark_way(mark_way)
  );

  function automatic logic [11:0] mk(input int tag, input int idx);
    return 12'((tag << 3) | idx);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [11:0] a, output logic h, output logic [1:0] w,
                        output logic [15:0] d);
    @(negedge clk); lk_req = 1'b1; lk_addr = a;
    @(negedge clk); lk_req = 1'b0;
    h = lk_hit; w = lk_way; d = lk_data;
  endtask

  task automatic fill(input logic [11:0] a, input logic [15:0] d,
                      output logic ok, output logic [1:0] w);
    @(negedge clk); fill_req = 1'b1; fill_addr = a; fill_data = d;
    @(negedge clk); fill_req = 1'b0;
    ok = fill_ok; w = fill_way;
  endtask

  task automatic mark(input int s, input int w);
    @(negedge clk); mark_req = 1'b1; mark_set = 3'(s); mark_way = 2'(w);
    @(negedge clk); mark_req = 1'b0;
  endtask

  task automatic t_reset;
    logic h; logic [1:0] w; logic [15:0] d;
    chk("R9", "lk_done after reset", int'(lk_done), 0);
    chk("R9", "fill_ok after reset", int'(fill_ok), 0);
    lookup(mk(0, 0), h, w, d);
    chk("R9", "lookup after reset hit", int'(h), 0);
  endtask

  task automatic t_basic;
    logic h, ok; logic [1:0] w; logic [15:0] d;
    fill(mk(5, 1), 16'h1111, ok, w);
    chk("R8", "first fill way", int'(w), 0);
    lookup(mk(5, 1), h, w, d);
    chk("R7", "lk_done one cycle after req", int'(lk_done), 1);
    chk("R7", "hit after fill", int'(h), 1);
    chk("R7", "data after fill", int'(d), 16'h1111);
    fill(mk(5, 1), 16'h2222, ok, w);
    chk("R8", "in-place overwrite way", int'(w), 0);
    lookup(mk(5, 1), h, w, d);
    chk("R8", "overwritten data", int'(d), 16'h2222);
    lookup(mk(6, 1), h, w, d);
    chk("R10", "other tag same set misses", int'(h), 0);
    lookup(mk(5, 2), h, w, d);
    chk("R10", "same tag other set misses", int'(h), 0);
  endtask

  task automatic t_same_cycle_fill;
    logic h; logic [1:0] w; logic [15:0] d;
    @(negedge clk);
    fill_req = 1'b1; fill_addr = mk(9, 4); fill_data = 16'h4444;
    lk_req = 1'b1; lk_addr = mk(9, 4);
    @(negedge clk);
    fill_req = 1'b0; lk_req = 1'b0;
    chk("R7", "lookup with same-cycle fill hit", int'(lk_hit), 0);
    chk("R8", "fill_done one cycle after req", int'(fill_done), 1);
    lookup(mk(9, 4), h, w, d);
    chk("R7", "lookup after fill hit", int'(h), 1);
  endtask

  task automatic t_round_robin;
    logic h, ok; logic [1:0] w; logic [15:0] d;
    mark(2, 1);
    fill(mk(1, 2), 16'hA001, ok, w); chk("R3", "fill A way", int'(w), 0);
    fill(mk(2, 2), 16'hA002, ok, w); chk("R3", "fill B way", int'(w), 2);
    fill(mk(3, 2), 16'hA003, ok, w); chk("R3", "fill C way", int'(w), 3);
    lookup(mk(1, 2), h, w, d); chk("R4", "A resident", int'(h), 1);
    lookup(mk(2, 2), h, w, d); chk("R4", "B resident", int'(h), 1);
    lookup(mk(3, 2), h, w, d); chk("R4", "C resident", int'(h), 1);
    fill(mk(4, 2), 16'hA004, ok, w); chk("R8", "rr victim D", int'(w), 0);
    fill(mk(5, 2), 16'hA005, ok, w); chk("R3", "rr skips faulty way", int'(w), 2);
    fill(mk(6, 2), 16'hA006, ok, w); chk("R8", "rr victim F", int'(w), 3);
    lookup(mk(5, 2), h, w, d);
    chk("R8", "E hit way", int'(w), 2);
    chk("R8", "E data", int'(d), 16'hA005);
    lookup(mk(1, 2), h, w, d); chk("R8", "A evicted", int'(h), 0);
  endtask

  task automatic t_fault_miss;
    logic h, ok; logic [1:0] w; logic [15:0] d;
    fill(mk(7, 5), 16'h5555, ok, w);
    lookup(mk(7, 5), h, w, d); chk("R2", "hit before mark", int'(h), 1);
    mark(5, 0);
    lookup(mk(7, 5), h, w, d); chk("R2", "miss after mark", int'(h), 0);
    for (int i = 0; i < 6; i++) begin
      fill(mk(20 + i, 5), 16'(i), ok, w);
      chk("R1", "faulty way never refilled", int'(w == 2'd0), 0);
    end
  endtask

  task automatic t_all_faulty;
    logic h, ok; logic [1:0] w; logic [15:0] d;
    fill(mk(3, 6), 16'h6666, ok, w);
    for (int i = 0; i < 4; i++) mark(6, i);
    lookup(mk(3, 6), h, w, d); chk("R5", "old line misses", int'(h), 0);
    fill(mk(8, 6), 16'h6767, ok, w); chk("R5", "fill_ok full-fault set", int'(ok), 0);
    lookup(mk(8, 6), h, w, d); chk("R5", "no allocation", int'(h), 0);
  endtask

  task automatic t_mark_timing;
    logic h, ok; logic [1:0] w; logic [15:0] d;
    fill(mk(11, 3), 16'h3333, ok, w);
    @(negedge clk);
    mark_req = 1'b1; mark_set = 3'd3; mark_way = 2'd0;
    lk_req = 1'b1; lk_addr = mk(11, 3);
    @(negedge clk);
    mark_req = 1'b0; lk_req = 1'b0;
    chk("R6", "same-cycle lookup sees old line", int'(lk_hit), 1);
    lookup(mk(11, 3), h, w, d); chk("R6", "next-cycle lookup misses", int'(h), 0);
    fill(mk(11, 3), 16'h3434, ok, w); chk("R6", "refill avoids marked way", int'(w), 1);
  endtask

  initial begin
    rst_n = 1'b0; lk_req = 0; fill_req = 0; mark_req = 0;
    lk_addr = '0; fill_addr = '0; fill_data = '0; mark_set = '0; mark_way = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_same_cycle_fill();
    t_round_robin();
    t_fault_miss();
    t_all_faulty();
    t_mark_timing();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule